// File: doc/BRIEF.md
# Single-Precision Result Rounding Stage

This stage takes the unrounded result of a floating-point operation and forms the final packed 32-bit single-precision word with its status flags. The input is a sign, a signed unbiased exponent and a normalized significand. The significand carries three extra low-order bits: guard, round and sticky. The stage rounds the value once, renormalizes when the round-up carries out of the significand, and range-checks the exponent. It then registers the packed word together with the overflow, underflow and inexact flags. The result appears one clock after the input strobe.

A two-bit mode field picks the rounding rule. Only the value 00 selects round to nearest with ties to even. Every other value selects round toward zero. On overflow the result saturates according to the mode: round to nearest yields a signed infinity, and round toward zero yields the signed largest finite value. Results too small to be normal are flushed to a signed zero.

Top module: `fp_round_unit`

## Requirements
- R1: With `rnd_mode` = 00, the result is the representable value nearest the input. The 24 retained bits are `in_sig[26:3]`, and `in_sig[2:0]` are discarded. The result rounds up when the discarded bits exceed 100. When they equal exactly 100, the result rounds up only if `in_sig[3]` is 1, so the tie goes to the even value.
- R2: With `rnd_mode` equal to 01, 10 or 11, the discarded bits `in_sig[2:0]` are dropped and never round the result up.
- R3: With `rnd_mode` = 00, overflow produces an infinity with the input sign: exponent field 0xFF and fraction 0. Overflow means a biased exponent of 255 or more after rounding, where the biased exponent is `in_exp` + 127, plus 1 on a carry. The result also raises `out_ovf` and `out_inx`.
- R4: With a toward-zero mode, the same overflow condition produces magnitude 0x7F7FFFFF with the input sign, and raises `out_ovf` and `out_inx`.
- R5: When round-up carries out of the 24-bit significand, the fraction becomes 0 and the exponent is incremented by one. That increment may itself cause the overflow of R3.
- R6: When the biased exponent after rounding is 0 or less, the output is a zero carrying the input sign, and `out_unf` and `out_inx` are set.
- R7: Outside overflow and underflow, `out_inx` equals whether `in_sig[2:0]` is nonzero. `out_ovf` and `out_unf` are 0. The word is {sign, biased exponent[7:0], rounded significand[22:0]}.
- R8: An all-zero `in_sig` yields a signed zero with all flags 0.
- R9: `out_valid` follows `in_valid` by exactly one clock. The flags are 0 in any cycle where `out_valid` is 0, and the word holds its last value.
- R10: While `rst_n` is low, `out_valid`, `out_word` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| in_sign | input | 1 | Sign of the unrounded value |
| in_exp | input | 10 | Signed unbiased exponent, two's complement |
| in_sig | input | 27 | Significand; bit 26 is the integer bit, bits 2:0 are guard, round, sticky |
| rnd_mode | input | 2 | 00 nearest-even, any other value toward zero |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_word | output | 32 | Packed single-precision result |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |

## Verification
The round-up carry and the exponent range check can act on the same input. A significand of all ones that rounds up at exponent 127 carries into the overflow of R3. An input at biased exponent −1 that carries up to 0 still counts as underflow. Directed inputs place the carry exactly at both exponent limits. Random exponents straddling both limits, mixed with forced ties, exercise the same interplay. Each output word and flag set is compared with a bench model that applies the rounding, carry and range steps in integer arithmetic.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
    localparam int MANT_W  = 24;
    localparam int EXTRA_W = 3;
    localparam int EXP_W   = 10;
    localparam int FIELD_W = 8;
    localparam int BIAS    = 127;
    localparam int SIG_W   = MANT_W + EXTRA_W;
    localparam int FRAC_W  = MANT_W - 1;
    localparam int WORD_W  = 1 + FIELD_W + FRAC_W;
    localparam int BEXP_W  = EXP_W + 2;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
        logic              ovf;
        logic              unf;
        logic              inx;
    } stage_t;
endpackage

// File: rtl/fpr_incr.sv
module fpr_incr
    import fpr_pkg::*;
(
    input  logic [SIG_W-1:0]  sig,
    input  logic              trunc,
    output logic [MANT_W:0]   sum,
    output logic              lost
);
    logic [MANT_W-1:0] kept;
    logic              guard;
    logic              sticky;
    logic              bump;

    always_comb begin
        kept   = sig[SIG_W-1:EXTRA_W];
        guard  = sig[EXTRA_W-1];
        sticky = |sig[EXTRA_W-2:0];
        bump   = !trunc && guard && (sticky || kept[0]);
        sum    = {1'b0, kept} + {{MANT_W{1'b0}}, bump};
        lost   = |sig[EXTRA_W-1:0];
    end
endmodule

// File: rtl/fpr_pack.sv
module fpr_pack
    import fpr_pkg::*;
(
    input  logic                    sign,
    input  logic signed [EXP_W-1:0] expo,
    input  logic [MANT_W:0]         sum,
    input  logic                    lost,
    input  logic                    trunc,
    input  logic                    is_zero,
    output logic [WORD_W-1:0]       word,
    output logic                    ovf,
    output logic                    unf,
    output logic                    inx
);
    localparam logic signed [BEXP_W-1:0] MAX_B = BEXP_W'((1 << FIELD_W) - 1);
    localparam logic signed [BEXP_W-1:0] BIAS_B = BEXP_W'(BIAS);

    logic                     carry;
    logic [FRAC_W-1:0]        frac;
    logic signed [BEXP_W-1:0] biased;

    always_comb begin
        carry  = sum[MANT_W];
        frac   = carry ? sum[MANT_W-1:1] : sum[FRAC_W-1:0];
        biased = BEXP_W'(expo) + BIAS_B + {{(BEXP_W-1){1'b0}}, carry};
        word   = '0;
        ovf    = 1'b0;
        unf    = 1'b0;
        inx    = 1'b0;
        if (is_zero) begin
            word = {sign, {(WORD_W-1){1'b0}}};
        end else if (biased >= MAX_B) begin
            ovf = 1'b1;
            inx = 1'b1;
            if (trunc)
                word = {sign, {(FIELD_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
            else
                word = {sign, {FIELD_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (biased <= 0) begin
            unf  = 1'b1;
            inx  = 1'b1;
            word = {sign, {(WORD_W-1){1'b0}}};
        end else begin
            inx  = lost;
            word = {sign, biased[FIELD_W-1:0], frac};
        end
    end
endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
    import fpr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [SIG_W-1:0]        in_sig,
    input  logic [1:0]              rnd_mode,
    output logic                    out_valid,
    output logic [WORD_W-1:0]       out_word,
    output logic                    out_ovf,
    output logic                    out_unf,
    output logic                    out_inx
);
    logic              trunc;
    logic [MANT_W:0]   sum;
    logic              lost;
    logic [WORD_W-1:0] p_word;
    logic              p_ovf, p_unf, p_inx;
    stage_t            st_d, st_q;

    assign trunc = (rnd_mode != 2'b00);

    fpr_incr u_incr (
        .sig   (in_sig),
        .trunc (trunc),
        .sum   (sum),
        .lost  (lost)
    );

    fpr_pack u_pack (
        .sign    (in_sign),
        .expo    (in_exp),
        .sum     (sum),
        .lost    (lost),
        .trunc   (trunc),
        .is_zero (in_sig == '0),
        .word    (p_word),
        .ovf     (p_ovf),
        .unf     (p_unf),
        .inx     (p_inx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.ovf   = 1'b0;
        st_d.unf   = 1'b0;
        st_d.inx   = 1'b0;
        if (in_valid) begin
            st_d.word = p_word;
            st_d.ovf  = p_ovf;
            st_d.unf  = p_unf;
            st_d.inx  = p_inx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;
    assign out_ovf   = st_q.ovf;
    assign out_unf   = st_q.unf;
    assign out_inx   = st_q.inx;
endmodule

// File: rtl/fpr_checker.sv
module fpr_checker
    import fpr_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_sign,
    input logic [1:0]              rnd_mode,
    input logic                    out_valid,
    input logic [WORD_W-1:0]       out_word,
    input logic                    out_ovf,
    input logic                    out_unf,
    input logic                    out_inx
);
    // R9
    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_stray_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_flags_need_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_ovf || out_unf || out_inx));
    // R3
    assert_inf_on_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ovf && $past(rnd_mode) == 2'b00) |-> out_word[WORD_W-2:0] == 31'h7F80_0000 && out_inx);
    // R4
    assert_max_on_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ovf && $past(rnd_mode) != 2'b00) |-> out_word[WORD_W-2:0] == 31'h7F7F_FFFF && out_inx);
    // R6
    assert_flush_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_unf |-> out_word[WORD_W-2:0] == '0 && out_inx && !out_ovf);
    // R7
    assert_no_top_exp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ovf) |-> out_word[WORD_W-2:FRAC_W] != {FIELD_W{1'b1}});
    assert_sign_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_word[WORD_W-1] == $past(in_sign));
endmodule

bind fp_round_unit fpr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sign   (in_sign),
    .rnd_mode  (rnd_mode),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_ovf   (out_ovf),
    .out_unf   (out_unf),
    .out_inx   (out_inx)
);

// File: tb/sim_fp_round_unit.sv
`timescale 1ns/1ps
module sim_fp_round_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_sign;
    logic [9:0]  in_exp;
    logic [26:0] in_sig;
    logic [1:0]  rnd_mode;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_ovf, out_unf, out_inx;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    fp_round_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .rnd_mode(rnd_mode),
        .out_valid(out_valid), .out_word(out_word),
        .out_ovf(out_ovf), .out_unf(out_unf), .out_inx(out_inx)
    );

    // returns {ovf, unf, inx, word}
    function automatic logic [34:0] model(input logic s, input int e,
                                          input logic [26:0] sig, input logic [1:0] md);
        int unsigned kept, rem, m;
        int b;
        logic up;
        logic [31:0] w;
        kept = int'(sig) >> 3;
        rem  = int'(sig) & 7;
        up   = (md == 2'b00) && (rem > 4 || (rem == 4 && (kept & 1) == 1));
        m    = kept + (up ? 1 : 0);
        if (m == 32'h0100_0000) begin m = 32'h0080_0000; e = e + 1; end
        b = e + 127;
        if (sig == 0) return {3'b000, s, 31'h0};
        if (b >= 255) begin
            w = (md == 2'b00) ? {s, 31'h7F80_0000} : {s, 31'h7F7F_FFFF};
            return {3'b101, w};
        end
        if (b <= 0) return {3'b011, s, 31'h0};
        w = {s, b[7:0], m[22:0]};
        return {2'b00, rem != 0, w};
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic s, input int e,
                         input logic [26:0] sig, input logic [1:0] md);
        logic [34:0] m;
        @(negedge clk);
        in_valid = 1'b1; in_sign = s; in_exp = 10'(e); in_sig = sig; rnd_mode = md;
        m = model(s, e, sig, md);
        @(posedge clk); #1;
        check(tag, {out_valid, out_ovf, out_unf, out_inx, out_word},
              {1'b1, m[34:32], m[31:0]});
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #1;
        check("R9 idle", {out_valid, out_ovf, out_unf, out_inx, out_word},
              {4'b0000, m[31:0]});
    endtask

    initial begin
        #1_500_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        rst_n = 1'b0; in_valid = 1'b0; in_sign = 1'b0; in_exp = '0; in_sig = '0; rnd_mode = 2'b00;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset", {out_valid, out_ovf, out_unf, out_inx, out_word}, 36'h0);
        @(negedge clk); rst_n = 1'b1;

        // R1 tie to even: lsb 0 stays, lsb 1 goes up; above half rounds up
        apply("R1 tie even stays", 1'b0, 0, 27'h4000004, 2'b00);
        apply("R1 tie odd up",     1'b0, 0, 27'h400000C, 2'b00);
        apply("R1 above half",     1'b1, 3, 27'h4000005, 2'b00);
        apply("R1 below half",     1'b0, 3, 27'h4000003, 2'b00);
        // R2 toward-zero modes
        apply("R2 mode01",         1'b0, 5, 27'h400000F, 2'b01);
        apply("R2 mode10",         1'b1, 5, 27'h7FFFFFF, 2'b10);
        apply("R2 mode11",         1'b0, 5, 27'h400000E, 2'b11);
        // R5 carry renormalizes
        apply("R5 carry",          1'b0, 10, 27'h7FFFFFC, 2'b00);
        // R3 carry into overflow, and plain overflow
        apply("R3 carry ovf",      1'b1, 127, 27'h7FFFFFC, 2'b00);
        apply("R3 ovf",            1'b0, 130, 27'h4000000, 2'b00);
        apply("R7 max exact",      1'b0, 127, 27'h7FFFFF8, 2'b00);
        // R4 saturate
        apply("R4 sat",            1'b1, 128, 27'h4000000, 2'b01);
        apply("R4 no carry at max",1'b0, 127, 27'h7FFFFFF, 2'b11);
        // R6 underflow, including carry from below into zero biased
        apply("R6 flush",          1'b1, -127, 27'h4000000, 2'b00);
        apply("R6 carry at -128",  1'b0, -128, 27'h7FFFFFC, 2'b00);
        apply("R7 min normal",     1'b0, -126, 27'h4000000, 2'b00);
        apply("R6 carry to normal",1'b0, -127, 27'h7FFFFFC, 2'b00);
        // R8 zero
        apply("R8 zero",           1'b1, 50, 27'h0, 2'b00);
        // R7 exact
        apply("R7 exact",          1'b0, 0, 27'h5555550, 2'b00);

        for (int i = 0; i < 3000; i++) begin
            logic [26:0] sg;
            int e;
            sg = {1'b1, 26'($urandom)};
            if (($urandom & 3) == 0) sg[2:0] = 3'b100;
            e  = int'($urandom % 281) - 140;
            apply("R1 R2 R7 random", 1'($urandom), e, sg, 2'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule